// File: doc/BRIEF.md
# Multi-Channel Prescaled Pulse-Width Modulator

This block drives a set of PWM outputs from one shared 8-bit time base. The input clock is first divided by a programmable 4-bit prescaler, which gives sixteen selectable local clock rates. An 8-bit counter steps once per local clock tick and wraps from 255 back to 0, so every period is 256 local ticks long. Each channel compares the shared count against its own duty value. The output is high from count 0 up to and including the duty value, so it is never fully low while the block runs.

Software configures the block through a simple 32-bit register bus. It writes the per-channel duty values, the prescale field, the global run bit and an interrupt enable. It can read back every setting and the live count. Duty and prescale writes are held in shadow registers and take effect only at a period boundary, so a pulse that is already running keeps its length. While the run bit is clear, the values are loaded immediately.

A sticky period-end flag is set at each wrap while the interrupt enable is on. Writing 1 to the flag clears it. The interrupt output is the flag gated by the enable.

Top module: `shared_pwm`

## Requirements
- R1: After reset all outputs and the interrupt are low, and every register reads as 0.
- R2: While the run bit is clear, the counter and prescaler stay at 0 and every channel output is low.
- R3: While running with prescale p, the counter advances once every p+1 input clocks and wraps from 255 to 0, so a period lasts 256*(p+1) input clocks.
- R4: A channel with duty value d is high for exactly (d+1)*(p+1) input clocks per period, starting at count 0. Duty 255 gives a constant high and duty 0 gives one local tick.
- R5: Register map (byte offsets, 32-bit registers). The duty of channel n is at 4*n, in bits [7:0]. Control is at 0x50, with the prescale in bits [3:0] and the run bit in bit 9. Interrupt enable is at 0x54, bit 0. The period-end flag is at 0x58, bit 0. The count is at 0x5C, bits [7:0], and is read-only. Unmapped offsets read 0, and writes to them and to 0x5C have no effect.
- R6: Setting the run bit starts a period at count 0 on the next input clock.
- R7: While running, duty and prescale writes are read back at once but reach the outputs and the counter only at the next 255-to-0 wrap.
- R8: The flag is set at a wrap only when the interrupt enable is 1. Writing 1 to bit 0 at 0x58 clears it and writing 0 leaves it. The interrupt output equals flag AND enable.
- R9: The counter read at 0x5C matches the live count in the same cycle.
- R10: Channels are independent: each output depends only on its own duty value and the shared count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 8 | Byte offset for both reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_o | output | NCH | Channel outputs |
| irq_o | output | 1 | Period-end interrupt |

## Verification
Register writes become visible on the first input clock after the write edge. A channel output follows the count with no added delay. The counter reads back in the same cycle. The flag sets on the same edge where the count wraps to 0. The bench drives every write on a falling edge and keeps counting samples on later falling edges, so sample k after a run write sees count floor(k/(p+1)) mod 256. Each expected high time, count value and interrupt level is computed from that index.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 32;
    localparam int RUN_BIT  = 9;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h50;
    localparam logic [ADDR_W-1:0] OFS_IRQEN = 8'h54;
    localparam logic [ADDR_W-1:0] OFS_FLAG  = 8'h58;
    localparam logic [ADDR_W-1:0] OFS_COUNT = 8'h5C;
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
    parameter int CNT_W = 8,
    parameter int PRE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [PRE_W-1:0] pre_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [PRE_W-1:0] div;
    } tb_t;

    tb_t  st_d, st_q;
    logic tick;

    always_comb begin
        st_d   = st_q;
        tick   = run_i && (st_q.div >= pre_i);
        wrap_o = tick && (st_q.cnt == '1);
        if (!run_i) begin
            st_d.cnt = '0;
            st_d.div = '0;
        end else if (tick) begin
            st_d.div = '0;
            st_d.cnt = st_q.cnt + 1'b1;
        end else begin
            st_d.div = st_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

    // R2
    held_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (st_q.cnt == '0 && st_q.div == '0));
    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (st_q.cnt == CNT_W'($past(st_q.cnt) + 1'b1)));
    // R3
    div_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !tick) |=> (st_q.div == PRE_W'($past(st_q.div) + 1'b1)));
endmodule

// File: rtl/pwm_compare.sv
module pwm_compare #(
    parameter int NCH   = 1,
    parameter int CNT_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      run_i,
    input  logic [CNT_W-1:0]          cnt_i,
    input  logic [NCH-1:0][CNT_W-1:0] duty_i,
    output logic [NCH-1:0]            pwm_o
);
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign pwm_o[g] = run_i && (cnt_i <= duty_i[g]);
    end

    // R2
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |-> (pwm_o == '0));
    // R4
    start_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && cnt_i == '0) |-> (pwm_o == '1));
endmodule

// File: rtl/pwm_regfile.sv
module pwm_regfile
    import pwm_pkg::*;
#(
    parameter int NCH   = 1,
    parameter int CNT_W = 8,
    parameter int PRE_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_we,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [DATA_W-1:0]         bus_wdata,
    output logic [DATA_W-1:0]         bus_rdata,
    input  logic [CNT_W-1:0]          cnt_i,
    input  logic                      wrap_i,
    output logic                      run_o,
    output logic [PRE_W-1:0]          pre_o,
    output logic [NCH-1:0][CNT_W-1:0] duty_o,
    output logic                      irq_o
);
    typedef struct packed {
        logic [NCH-1:0][CNT_W-1:0] duty_sh;
        logic [NCH-1:0][CNT_W-1:0] duty_act;
        logic [PRE_W-1:0]          pre_sh;
        logic [PRE_W-1:0]          pre_act;
        logic                      run;
        logic                      irq_en;
        logic                      flag;
    } rf_t;

    rf_t  st_d, st_q;
    logic unused_wdata;

    assign unused_wdata = ^bus_wdata;

    always_comb begin
        st_d = st_q;
        for (int ch = 0; ch < NCH; ch++) begin
            if (bus_we && bus_addr == ADDR_W'(ch * 4))
                st_d.duty_sh[ch] = bus_wdata[CNT_W-1:0];
        end
        if (bus_we && bus_addr == OFS_CTRL) begin
            st_d.pre_sh = bus_wdata[PRE_W-1:0];
            st_d.run    = bus_wdata[RUN_BIT];
        end
        if (bus_we && bus_addr == OFS_IRQEN)
            st_d.irq_en = bus_wdata[0];
        if (bus_we && bus_addr == OFS_FLAG && bus_wdata[0])
            st_d.flag = 1'b0;
        if (wrap_i && st_q.irq_en)
            st_d.flag = 1'b1;
        if (!st_q.run || wrap_i) begin
            st_d.duty_act = st_d.duty_sh;
            st_d.pre_act  = st_d.pre_sh;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        for (int ch = 0; ch < NCH; ch++) begin
            if (bus_addr == ADDR_W'(ch * 4))
                bus_rdata[CNT_W-1:0] = st_q.duty_sh[ch];
        end
        case (bus_addr)
            OFS_CTRL: begin
                bus_rdata[PRE_W-1:0] = st_q.pre_sh;
                bus_rdata[RUN_BIT]   = st_q.run;
            end
            OFS_IRQEN: bus_rdata[0]         = st_q.irq_en;
            OFS_FLAG:  bus_rdata[0]         = st_q.flag;
            OFS_COUNT: bus_rdata[CNT_W-1:0] = cnt_i;
            default: ;
        endcase
    end

    assign run_o  = st_q.run;
    assign pre_o  = st_q.pre_act;
    assign duty_o = st_q.duty_act;
    assign irq_o  = st_q.flag & st_q.irq_en;

    // R7
    active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && !wrap_i) |=> ($stable(st_q.duty_act) && $stable(st_q.pre_act)));
    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> st_q.irq_en);
    // R8
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_i && st_q.irq_en) |=> st_q.flag);
endmodule

// File: rtl/shared_pwm.sv
module shared_pwm
    import pwm_pkg::*;
#(
    parameter int NCH   = 1,
    parameter int CNT_W = 8,
    parameter int PRE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NCH-1:0]    pwm_o,
    output logic              irq_o
);
    logic                      run;
    logic [PRE_W-1:0]          pre_act;
    logic [NCH-1:0][CNT_W-1:0] duty_act;
    logic [CNT_W-1:0]          cnt;
    logic                      wrap;

    pwm_regfile #(.NCH(NCH), .CNT_W(CNT_W), .PRE_W(PRE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_i(cnt),
        .wrap_i(wrap), .run_o(run), .pre_o(pre_act), .duty_o(duty_act),
        .irq_o(irq_o)
    );

    pwm_timebase #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .run_i(run), .pre_i(pre_act),
        .cnt_o(cnt), .wrap_o(wrap)
    );

    pwm_compare #(.NCH(NCH), .CNT_W(CNT_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .run_i(run), .cnt_i(cnt),
        .duty_i(duty_act), .pwm_o(pwm_o)
    );
endmodule

// File: tb/sim_shared_pwm.sv
module sim_shared_pwm;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 3;
    localparam int RUN = 1 << 9;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           bus_we;
    logic [7:0]     bus_addr;
    logic [31:0]    bus_wdata;
    logic [31:0]    bus_rdata;
    logic [NCH-1:0] pwm_o;
    logic           irq_o;

    int errors = 0;
    int checks = 0;
    int hi [NCH];
    logic [31:0] rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    shared_pwm #(.NCH(NCH)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_o(pwm_o), .irq_o(irq_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input int d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic measure(input int ncyc);
        for (int k = 0; k < NCH; k++) hi[k] = 0;
        for (int i = 0; i < ncyc; i++) begin
            for (int k = 0; k < NCH; k++) if (pwm_o[k]) hi[k]++;
            @(negedge clk);
        end
    endtask

    task automatic run_cfg(input int pre, input int d0, input int d1, input int d2);
        int dv [NCH];
        dv[0] = d0; dv[1] = d1; dv[2] = d2;
        wr(8'h50, 0);
        for (int k = 0; k < NCH; k++) wr(8'(4 * k), dv[k]);
        wr(8'h50, RUN | pre);
        measure(256 * (pre + 1));
        // R4 R10: high time per channel
        for (int k = 0; k < NCH; k++)
            chk(hi[k] == (dv[k] + 1) * (pre + 1), "R4/R10 high time", hi[k], (dv[k] + 1) * (pre + 1));
        // R3: next period starts at count 0
        rd(8'h5C, rv);
        chk(rv == 0, "R3 wrap to 0", int'(rv), 0);
        chk(pwm_o == '1, "R3 new period high", int'(pwm_o), 7);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(pwm_o == '0, "R1 outputs", int'(pwm_o), 0);
        chk(irq_o == 1'b0, "R1 irq", int'(irq_o), 0);
        rd(8'h50, rv); chk(rv == 0, "R1 ctrl", int'(rv), 0);
        rd(8'h00, rv); chk(rv == 0, "R1 duty0", int'(rv), 0);
        rd(8'h58, rv); chk(rv == 0, "R1 flag", int'(rv), 0);

        // R2 idle: duties at max, run bit clear
        wr(8'h00, 255); wr(8'h04, 255); wr(8'h08, 255);
        wr(8'h50, 5);
        for (int i = 0; i < 20; i++) begin
            if (i % 5 == 0) begin
                chk(pwm_o == '0, "R2 idle outputs", int'(pwm_o), 0);
                rd(8'h5C, rv); chk(rv == 0, "R2 idle count", int'(rv), 0);
            end
            @(negedge clk);
        end

        // R5 map, read-only count, unmapped offsets
        rd(8'h50, rv); chk(rv == 5, "R5 ctrl readback", int'(rv), 5);
        rd(8'h04, rv); chk(rv == 255, "R5 duty1 readback", int'(rv), 255);
        wr(8'h5C, 77);
        rd(8'h5C, rv); chk(rv == 0, "R5 count read-only", int'(rv), 0);
        wr(8'h40, 99);
        rd(8'h40, rv); chk(rv == 0, "R5 unmapped", int'(rv), 0);
        chk(pwm_o == '0, "R5 unmapped write no effect", int'(pwm_o), 0);

        // R4 R10 sweep with prescale 0
        for (int d = 0; d < 256; d += 3)
            run_cfg(0, d, (d + 1 > 255) ? 255 : d + 1, (d + 2 > 255) ? 255 : d + 2);
        // R3 R4 other prescales
        run_cfg(1, 0, 127, 255);
        run_cfg(2, 255, 0, 64);
        run_cfg(15, 10, 200, 255);

        // R3 R9 counter readback with prescale 2
        wr(8'h50, 0);
        wr(8'h50, RUN | 2);
        for (int i = 0; i < 800; i++) begin
            rd(8'h5C, rv);
            chk(rv == (i / 3) % 256, "R9/R3 count", int'(rv), (i / 3) % 256);
            @(negedge clk);
        end

        // R6 restart from count 0
        wr(8'h50, 0);
        wr(8'h50, RUN);
        rd(8'h5C, rv); chk(rv == 0, "R6 start count", int'(rv), 0);
        chk(pwm_o == '1, "R6 start high", int'(pwm_o), 7);

        // R7 deferred duty change
        wr(8'h50, 0);
        wr(8'h00, 50);
        wr(8'h50, RUN);
        hi[0] = 0;
        for (int i = 0; i < 256; i++) begin
            if (pwm_o[0]) hi[0]++;
            if (i == 3) wr(8'h00, 5);
            else @(negedge clk);
        end
        chk(hi[0] == 51, "R7 old duty kept", hi[0], 51);
        rd(8'h00, rv); chk(rv == 5, "R7 shadow readback", int'(rv), 5);
        measure(256);
        chk(hi[0] == 6, "R7 new duty applied", hi[0], 6);

        // R7 deferred prescale change
        wr(8'h50, 0);
        wr(8'h50, RUN);
        for (int i = 0; i < 260; i++) begin
            if (i == 255) begin rd(8'h5C, rv); chk(rv == 255, "R7 prescale defer", int'(rv), 255); end
            if (i == 256) begin rd(8'h5C, rv); chk(rv == 0, "R7 prescale wrap", int'(rv), 0); end
            if (i == 257) begin rd(8'h5C, rv); chk(rv == 0, "R7 prescale applied", int'(rv), 0); end
            if (i == 258) begin rd(8'h5C, rv); chk(rv == 1, "R7 prescale step", int'(rv), 1); end
            if (i == 100) wr(8'h50, RUN | 1);
            else @(negedge clk);
        end

        // R8 interrupt
        wr(8'h50, 0);
        wr(8'h54, 1);
        wr(8'h50, RUN);
        for (int i = 0; i < 257; i++) begin
            if (i == 255) chk(irq_o == 1'b0, "R8 irq before wrap", int'(irq_o), 0);
            if (i == 256) chk(irq_o == 1'b1, "R8 irq at wrap", int'(irq_o), 1);
            if (i < 256) @(negedge clk);
        end
        wr(8'h58, 0);
        chk(irq_o == 1'b1, "R8 write 0 keeps flag", int'(irq_o), 1);
        wr(8'h58, 1);
        chk(irq_o == 1'b0, "R8 write 1 clears", int'(irq_o), 0);
        wr(8'h54, 0);
        repeat (300) @(negedge clk);
        rd(8'h58, rv); chk(rv == 0, "R8 no flag when disabled", int'(rv), 0);
        chk(irq_o == 1'b0, "R8 irq off", int'(irq_o), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule